// File: doc/BRIEF.md
# Two-Step Flash Code Assembler

This block is the digital back end of a converter that resolves a 10-bit result in two flash steps. A small set of six coarse comparators gives a rough estimate of where the input lies. From that estimate the block chooses which 16-tap slice of the 64-tap upper ladder a shared bank of sixteen fine comparators should watch. It then reads those comparators once to settle the upper six bits. The same sixteen comparators are read a second time against the lower ladder to settle the bottom four bits.

Comparator outputs arrive as thermometer vectors, with bit 0 holding the lowest threshold. Each vector is qualified by a strobe. A start pulse opens a conversion. The block drives the window index for the comparator multiplexer and the chosen upper tap for the residue subtraction. At the end it latches the final code and pulses a done strobe. Because the window reaches past the estimated region on both sides, an estimate that is off by a few taps is corrected without any extra step.

Top module: `twostep_code_assembler`

## Requirements
- R1: While reset is held and right after it is released, winBase, residueTap and code are 0, and done and bubbleErr are low.
- R2: A start in the idle phase begins a conversion. The block then takes exactly three qualified samples, in this order: coarse vector, first fine vector, second fine vector. cmpValid while idle has no effect, and start while a conversion is running has no effect.
- R3: done is high for exactly one cycle, the cycle after the edge that samples the second fine vector. code takes its new value at that same edge.
- R4: With r equal to the number of ones in the coarse vector, winBase becomes 8*r-4, floored at 0. When all six coarse bits are set it becomes 48. It updates at the coarse sampling edge and never exceeds 48.
- R5: At the first fine sampling edge, residueTap becomes winBase plus the fine count minus 1, saturated to the range 0 to 63.
- R6: At the second fine sampling edge, code becomes {residueTap, lsb}, with residueTap in bits 9:4. lsb is the fine count limited to 15.
- R7: code holds its value between latch edges. An input at the bottom of the range yields 0, and an input one LSB below full scale yields 1023.
- R8: Each vector's count is its number of contiguous ones starting at bit 0. A one above the first zero sets bubbleErr, which then stays high until reset.
- R9: For true upper taps in the middle regions, a coarse estimate shifted by up to 4 taps (64 LSB) either way still gives the correct residueTap and code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a conversion when idle |
| cmpValid | input | 1 | Qualifies the comparator vector of the current phase |
| coarseTherm | input | 6 | Coarse estimator thermometer vector |
| fineTherm | input | 16 | Shared fine comparator thermometer vector |
| winBase | output | 6 | First upper-ladder tap of the fine comparator window |
| residueTap | output | 6 | Upper tap just below the input, used for the residue |
| code | output | 10 | Latched conversion result |
| done | output | 1 | One-cycle pulse when code is updated |
| bubbleErr | output | 1 | Sticky flag for a non-monotonic thermometer vector |

## Verification
A wrong phase in the sequencer shows up within one conversion. Either a vector lands in the wrong register, which the bench reads as a wrong winBase or residueTap at the next sampling point, or done appears in a cycle other than the one after the final sample. An arithmetic error in the window or saturation logic is visible on winBase or residueTap one cycle after the sampling edge, before the code is even latched. A bad bubble decode or a flag that fails to hold shows on bubbleErr at the end of the conversion that carried the bubble, or at the end of the next clean one.

// File: rtl/tsca_pkg.sv
package tsca_pkg;

  localparam int COARSE_N_DEF    = 6;
  localparam int FINE_N_DEF      = 16;
  localparam int MSB_BITS_DEF    = 6;
  localparam int REGION_STEP_DEF = 8;
  localparam int WIN_MARGIN_DEF  = 4;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_COARSE = 3'd1,
    PH_MSB    = 3'd2,
    PH_LSB    = 3'd3,
    PH_LATCH  = 3'd4
  } tscaPhase_t;

  typedef struct packed {
    logic loadCoarse;
    logic loadMsb;
    logic loadLsb;
  } tscaStrobes_t;

endpackage

// File: rtl/tsca_therm_decode.sv
module tsca_therm_decode #(
  parameter int N  = 16,
  parameter int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  therm,
  output logic [CW-1:0] count,
  output logic          bubble
);

  logic [N-1:0] run;

  // run[i] is set while every comparator from 0 up to i has tripped
  assign run[0] = therm[0];
  generate
    for (genvar i = 1; i < N; i++) begin : g_run
      assign run[i] = run[i-1] & therm[i];
    end
  endgenerate

  always_comb begin
    count = '0;
    for (int i = 0; i < N; i++) begin
      count = count + CW'(run[i]);
    end
  end

  // any tripped comparator above the first untripped one is a bubble
  assign bubble = |(therm & ~run);

endmodule

// File: rtl/tsca_ctrl.sv
module tsca_ctrl
  import tsca_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         cmpValid,
  output tscaStrobes_t strb,
  output logic         done
);

  tscaPhase_t phase, phaseNext;

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_IDLE:   if (start)    phaseNext = PH_COARSE;
      PH_COARSE: if (cmpValid) phaseNext = PH_MSB;
      PH_MSB:    if (cmpValid) phaseNext = PH_LSB;
      PH_LSB:    if (cmpValid) phaseNext = PH_LATCH;
      PH_LATCH:                phaseNext = PH_IDLE;
      default:                 phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  always_comb begin
    strb.loadCoarse = (phase == PH_COARSE) && cmpValid;
    strb.loadMsb    = (phase == PH_MSB)    && cmpValid;
    strb.loadLsb    = (phase == PH_LSB)    && cmpValid;
  end

  assign done = (phase == PH_LATCH);

  // R3: the done pulse is a single cycle wide
  a_r3_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R3: the final sample is followed by done in the next cycle
  a_r3_done_after_lsb: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadLsb |=> done);

  // R2: a start arriving mid-conversion never restarts the coarse phase
  a_r2_busy_start: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadMsb && start) |=> (phase == PH_LSB));

endmodule

// File: rtl/tsca_datapath.sv
module tsca_datapath
  import tsca_pkg::*;
#(
  parameter int COARSE_N    = COARSE_N_DEF,
  parameter int FINE_N      = FINE_N_DEF,
  parameter int MSB_BITS    = MSB_BITS_DEF,
  parameter int REGION_STEP = REGION_STEP_DEF,
  parameter int WIN_MARGIN  = WIN_MARGIN_DEF,
  localparam int LSB_BITS   = $clog2(FINE_N),
  localparam int CODE_W     = MSB_BITS + LSB_BITS
) (
  input  logic                clk,
  input  logic                rstN,
  input  tscaStrobes_t        strb,
  input  logic [COARSE_N-1:0] coarseTherm,
  input  logic [FINE_N-1:0]   fineTherm,
  output logic [MSB_BITS-1:0] winBase,
  output logic [MSB_BITS-1:0] residueTap,
  output logic [CODE_W-1:0]   code,
  output logic                bubbleErr
);

  localparam int RCW      = $clog2(COARSE_N + 1);
  localparam int FCW      = $clog2(FINE_N + 1);
  localparam int SW       = MSB_BITS + 2;
  localparam int MAX_TAP  = (1 << MSB_BITS) - 1;
  localparam int MAX_BASE = (1 << MSB_BITS) - FINE_N;
  localparam int LSB_MAX  = FINE_N - 1;

  logic [RCW-1:0]      coarseCnt;
  logic                coarseBubble;
  logic [FCW-1:0]      fineCnt;
  logic                fineBubble;
  logic [SW-1:0]       scaled;
  logic [MSB_BITS-1:0] baseNext;
  logic [SW-1:0]       tapSum;
  logic [MSB_BITS-1:0] tapNext;
  logic [LSB_BITS-1:0] lsbNext;

  tsca_therm_decode #(.N(COARSE_N), .CW(RCW)) i_coarseDec (
    .therm  (coarseTherm),
    .count  (coarseCnt),
    .bubble (coarseBubble)
  );

  // one decoder serves both fine flashes, as the comparators are shared
  tsca_therm_decode #(.N(FINE_N), .CW(FCW)) i_fineDec (
    .therm  (fineTherm),
    .count  (fineCnt),
    .bubble (fineBubble)
  );

  // window placement: region scaled to taps, pulled down by the margin
  always_comb begin
    scaled = SW'(coarseCnt) * SW'(REGION_STEP);
    if (coarseCnt == RCW'(COARSE_N))
      baseNext = MSB_BITS'(MAX_BASE);
    else if (scaled < SW'(WIN_MARGIN))
      baseNext = '0;
    else if (scaled - SW'(WIN_MARGIN) > SW'(MAX_BASE))
      baseNext = MSB_BITS'(MAX_BASE);
    else
      baseNext = MSB_BITS'(scaled - SW'(WIN_MARGIN));
  end

  // upper tap below the input: last tripped comparator in the window
  always_comb begin
    tapSum = SW'(winBase) + SW'(fineCnt);
    if (tapSum == '0)
      tapNext = '0;
    else if (tapSum - SW'(1) > SW'(MAX_TAP))
      tapNext = MSB_BITS'(MAX_TAP);
    else
      tapNext = MSB_BITS'(tapSum - SW'(1));
  end

  always_comb begin
    if (fineCnt > FCW'(LSB_MAX)) lsbNext = LSB_BITS'(LSB_MAX);
    else                         lsbNext = LSB_BITS'(fineCnt);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winBase    <= '0;
      residueTap <= '0;
      code       <= '0;
      bubbleErr  <= 1'b0;
    end else begin
      if (strb.loadCoarse) winBase    <= baseNext;
      if (strb.loadMsb)    residueTap <= tapNext;
      if (strb.loadLsb)    code       <= {residueTap, lsbNext};
      if ((strb.loadCoarse && coarseBubble) ||
          ((strb.loadMsb || strb.loadLsb) && fineBubble))
        bubbleErr <= 1'b1;
    end
  end

  // R4: the window never runs past the top of the ladder
  a_r4_base_bound: assert property (@(posedge clk) disable iff (!rstN)
    winBase <= MSB_BITS'(MAX_BASE));

  // R8: once raised the error flag stays up
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rstN)
    bubbleErr |=> bubbleErr);

  // R7: the code moves only on the final sampling edge
  a_r7_code_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadLsb |=> $stable(code));

  // R2: the control never asks for two samples at once
  a_r2_one_load: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadCoarse, strb.loadMsb, strb.loadLsb}));

  // R5: the residue tap keeps its value outside the first fine sample
  a_r5_tap_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadMsb |=> $stable(residueTap));

endmodule

// File: rtl/twostep_code_assembler.sv
module twostep_code_assembler
  import tsca_pkg::*;
#(
  parameter int COARSE_N    = COARSE_N_DEF,
  parameter int FINE_N      = FINE_N_DEF,
  parameter int MSB_BITS    = MSB_BITS_DEF,
  parameter int REGION_STEP = REGION_STEP_DEF,
  parameter int WIN_MARGIN  = WIN_MARGIN_DEF,
  localparam int CODE_W     = MSB_BITS + $clog2(FINE_N)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic                cmpValid,
  input  logic [COARSE_N-1:0] coarseTherm,
  input  logic [FINE_N-1:0]   fineTherm,
  output logic [MSB_BITS-1:0] winBase,
  output logic [MSB_BITS-1:0] residueTap,
  output logic [CODE_W-1:0]   code,
  output logic                done,
  output logic                bubbleErr
);

  tscaStrobes_t strb;

  tsca_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .cmpValid (cmpValid),
    .strb     (strb),
    .done     (done)
  );

  tsca_datapath #(
    .COARSE_N    (COARSE_N),
    .FINE_N      (FINE_N),
    .MSB_BITS    (MSB_BITS),
    .REGION_STEP (REGION_STEP),
    .WIN_MARGIN  (WIN_MARGIN)
  ) i_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .coarseTherm (coarseTherm),
    .fineTherm   (fineTherm),
    .winBase     (winBase),
    .residueTap  (residueTap),
    .code        (code),
    .bubbleErr   (bubbleErr)
  );

endmodule

// File: tb/test_twostep_code_assembler.sv
module test_twostep_code_assembler;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        cmpValid = 1'b0;
  logic [5:0]  coarseTherm = '0;
  logic [15:0] fineTherm = '0;
  logic [5:0]  winBase;
  logic [5:0]  residueTap;
  logic [9:0]  code;
  logic        done;
  logic        bubbleErr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  int obsBase, obsTap, obsCode, obsDoneHi, obsDoneLo;

  twostep_code_assembler i_twostep_code_assembler (
    .clk, .rstN, .start, .cmpValid, .coarseTherm, .fineTherm,
    .winBase, .residueTap, .code, .done, .bubbleErr
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] therm(input int n);
    int v;
    v = (1 << n) - 1;
    return v[15:0];
  endfunction

  function automatic int baseOf(input int r);
    if (r == 6) return 48;
    if (r * 8 < 4) return 0;
    return r * 8 - 4;
  endfunction

  task automatic runConv(input logic [5:0] cv, input logic [15:0] mv,
                         input logic [15:0] lv, input bit holdStart);
    @(negedge clk); start = 1'b1;
    @(negedge clk); if (!holdStart) start = 1'b0;
    coarseTherm = cv; cmpValid = 1'b1;
    @(negedge clk); obsBase = winBase; fineTherm = mv;
    @(negedge clk); obsTap = residueTap; fineTherm = lv;
    @(negedge clk); cmpValid = 1'b0; start = 1'b0;
    obsDoneHi = done; obsCode = code;
    @(negedge clk); obsDoneLo = done;
  endtask

  // analog model: input v, estimator shifted by d taps
  task automatic convValue(input string req, input int v, input int d,
                           input bit holdStart);
    int t, tp, r, b, c1;
    t  = v >> 4;
    tp = t + d;
    if (tp < 0) tp = 0;
    if (tp > 63) tp = 63;
    r  = (tp >= 48) ? 6 : tp / 8;
    b  = baseOf(r);
    c1 = t - b + 1;
    if (c1 < 0) c1 = 0;
    if (c1 > 16) c1 = 16;
    runConv(therm(r)[5:0], therm(c1), therm(v & 15), holdStart);
    chk({req, " winBase"}, obsBase, b);
    chk({req, " residueTap"}, obsTap, t);
    chk({req, " code"}, obsCode, v);
    chk("R3 done high", obsDoneHi, 1);
    chk("R3 done low after", obsDoneLo, 0);
  endtask

  task automatic tReset();
    @(negedge clk);
    chk("R1 winBase", winBase, 0);
    chk("R1 residueTap", residueTap, 0);
    chk("R1 code", code, 0);
    chk("R1 done", done, 0);
    chk("R1 bubbleErr", bubbleErr, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 code after release", code, 0);
    chk("R1 done after release", done, 0);
  endtask

  task automatic tExtremes();
    convValue("R7 bottom", 0, 0, 0);
    convValue("R7 top", 1023, 0, 0);
  endtask

  task automatic tMidRange();
    convValue("R5 R6 mid a", 325, 0, 0);
    convValue("R5 R6 mid b", 700, 0, 0);
    convValue("R5 R6 mid c", 517, 0, 0);
  endtask

  task automatic tWindows();
    // R4: every region, checked directly on winBase
    for (int r = 0; r <= 6; r++) begin
      runConv(therm(r)[5:0], 16'h0000, 16'h0000, 0);
      chk("R4 window for region", obsBase, baseOf(r));
    end
  endtask

  task automatic tSaturation();
    // R5: base 0, no fine comparator tripped -> tap saturates at 0
    runConv(6'b000000, 16'h0000, 16'hFFFF, 0);
    chk("R5 low saturation", obsTap, 0);
    // R6: all sixteen tripped in the second flash -> lsb 15
    chk("R6 lsb limit", obsCode, 15);
    // R5: top window full -> tap 63
    runConv(6'b111111, 16'hFFFF, 16'h0000, 0);
    chk("R5 top tap", obsTap, 63);
    chk("R6 field position", obsCode, 63 * 16);
  endtask

  task automatic tTolerance();
    convValue("R9 estimate high", 20 * 16 + 5, 4, 0);
    convValue("R9 estimate low", 20 * 16 + 5, -4, 0);
    convValue("R9 estimate high b", 27 * 16 + 9, 4, 0);
    convValue("R9 estimate low b", 27 * 16 + 9, -4, 0);
  endtask

  task automatic tIgnored();
    int b0, t0, c0;
    convValue("R2 busy start", 600, 0, 1);
    b0 = winBase; t0 = residueTap; c0 = code;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      cmpValid = 1'b1; coarseTherm = 6'b111111; fineTherm = 16'h00FF;
      @(negedge clk);
      chk("R2 idle cmpValid done", done, 0);
    end
    cmpValid = 1'b0;
    @(negedge clk);
    chk("R2 idle winBase", winBase, b0);
    chk("R2 idle residueTap", residueTap, t0);
    chk("R7 code hold", code, c0);
  endtask

  task automatic tBubble();
    chk("R8 flag clear before", bubbleErr, 0);
    // coarse leading ones 1 -> base 4; fine 0 -> tap 3; lsb 15
    runConv(6'b000101, 16'h0000, 16'hFFFF, 0);
    chk("R8 coarse leading ones", obsBase, 4);
    chk("R8 tap from leading ones", obsTap, 3);
    chk("R8 code", obsCode, 63);
    chk("R8 flag raised", bubbleErr, 1);
    convValue("R8 clean after bubble", 400, 0, 0);
    chk("R8 flag sticky", bubbleErr, 1);
    // fine bubble: leading ones 2 in second flash
    runConv(6'b000011, 16'h0003, 16'h00F3, 0);
    chk("R8 fine leading ones", obsCode, ((12 + 2 - 1) * 16) + 2);
  endtask

  initial begin
    tReset();
    tExtremes();
    tMidRange();
    tWindows();
    tSaturation();
    tTolerance();
    tIgnored();
    tBubble();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG && !finished) begin
        finished = 1;
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

endmodule